// File: doc/BRIEF.md
# Configurable Port Pin Controller

This block owns the configuration and output state of a bank of general-purpose I/O ports. The default is four ports of eight pins. For every pin it drives three pad controls: an output enable, an output level and a weak pull-up enable. Each port has a data latch and an output-style register. One port also has an input-style register, which can turn any of its pins into an analog input. A single global bit can switch off every weak pull-up.

Software reaches the registers over a small synchronous register bus. A write can replace a whole byte or change one selected bit. Reads return data one cycle after the request. A read of a data register can be tagged as the read half of a read-modify-write. Such a read returns the latch contents. An ordinary read returns the level seen at the pads instead.

Pins that a peripheral has taken over are marked by override inputs from the pin-assignment logic. On those pins the peripheral's output level replaces the data bit, or the driver is released when the peripheral uses the pin as an input. The configured output style still applies to them.

Top module: `port_pin_ctrl`

Address layout: `bus_addr = {kind[1:0], port}`. The kinds are: 0 = data latch, 1 = output style (bit 1 = push-pull, 0 = open-drain), 2 = input style (bit 0 = analog, 1 = digital), 3 = global control (bit 0 = pull-up kill). Pin `b` of port `p` is bit `p*8+b` of every flat pad vector.

## Requirements
- R1: After reset every data latch is 0xFF, every pin is open-drain, pull-ups are enabled and no analog pin exists. So `pad_oe` is all zeros and `pad_pu` is all ones.
- R2: A pin in push-pull style (output-style bit 1) has `pad_oe`=1 and `pad_out` equal to its data bit.
- R3: A pin in open-drain style (output-style bit 0) drives low (`pad_oe`=1, `pad_out`=0) when its data bit is 0. When the bit is 1 its driver is released (`pad_oe`=0, `pad_out`=0).
- R4: The weak pull-up of a digital pin is off exactly while that pin drives low; otherwise it is on, unless R5 applies.
- R5: When global control bit 0 is 1, `pad_pu` is all zeros. Clearing it restores R4 behaviour. The bit reads back at bit 0 of kind 3.
- R6: An ordinary read of a data register (`bus_rmw`=0) returns the digital pad levels `pad_in` of that port, including pins owned by a peripheral.
- R7: A data-register read with `bus_rmw`=1 returns the latch contents, not the pad levels.
- R8: A write with `bus_bit_en`=1 changes only bit `bus_bit_sel` of the addressed register, taking its value from `bus_wdata[0]`. A write with `bus_bit_en`=0 replaces the whole register.
- R9: On the analog-capable port (port 1), an input-style bit of 0 makes that pin analog. Its `pad_oe`, `pad_out` and `pad_pu` are 0, and its bit reads 0 on an ordinary data read.
- R10: Where `xbar_own`=1 and `xbar_oe`=1, the pin uses `xbar_out` in place of its data bit under its configured output style. Where `xbar_own`=1 and `xbar_oe`=0, the driver is released.
- R11: Input-style writes to ports without analog capability are ignored. Their input-style register reads 0xFF and their pads stay unchanged.
- R12: `bus_rdata` updates on the clock edge that samples `bus_re`=1 and holds its value while `bus_re` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_rmw | input | 1 | Read is the first half of a read-modify-write |
| bus_bit_en | input | 1 | Write changes one bit only |
| bus_bit_sel | input | 3 | Bit selected for a single-bit write |
| bus_addr | input | 4 | {kind, port} register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after `bus_re` |
| pad_in | input | 32 | Pad input levels |
| xbar_own | input | 32 | Pin is owned by a peripheral |
| xbar_oe | input | 32 | Owning peripheral drives the pin |
| xbar_out | input | 32 | Owning peripheral's output level |
| pad_oe | output | 32 | Pad output enable |
| pad_out | output | 32 | Pad output level |
| pad_pu | output | 32 | Pad weak pull-up enable |

## Verification
The pad controls depend combinationally on the registers. They therefore reflect a write in the cycle right after the clock edge that accepts it. The bench samples them at the next falling edge after the write strobe drops. Read data arrives one edge after `bus_re` is sampled. The driver queues each expected byte when it raises `bus_re`. The monitor pops and compares an entry only at a falling edge that follows a sampled read, so every comparison lands exactly one cycle after its request. Hold behaviour is checked after several idle cycles.

// File: rtl/pp_pkg.sv
package pp_pkg;
   localparam int KIND_W = 2;

   typedef enum logic [KIND_W-1:0] {
      RK_DATA   = 2'd0,
      RK_OSTYLE = 2'd1,
      RK_ISTYLE = 2'd2,
      RK_GLOBAL = 2'd3
   } reg_kind_e;
endpackage

// File: rtl/pp_regfile.sv
module pp_regfile
   import pp_pkg::*;
#(
   parameter int NUM_PORTS   = 4,
   parameter int PORT_W      = 8,
   parameter int ANALOG_PORT = 1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          we,
   input  logic                          bit_en,
   input  logic [$clog2(PORT_W)-1:0]     bit_sel,
   input  logic [KIND_W-1:0]             kind,
   input  logic [$clog2(NUM_PORTS)-1:0]  port,
   input  logic [PORT_W-1:0]             wdata,
   output logic [NUM_PORTS*PORT_W-1:0]   data_o,
   output logic [NUM_PORTS*PORT_W-1:0]   ostyle_o,
   output logic [NUM_PORTS*PORT_W-1:0]   istyle_o,
   output logic                          pu_kill_o
);
   localparam int PIX_W = $clog2(NUM_PORTS);

   // Apply a byte write, or replace the single selected bit
   function automatic logic [PORT_W-1:0] merge(input logic [PORT_W-1:0] old_v,
                                               input logic [PORT_W-1:0] wd,
                                               input logic              ben,
                                               input logic [$clog2(PORT_W)-1:0] sel);
      logic [PORT_W-1:0] r;
      if (ben) begin
         r      = old_v;
         r[sel] = wd[0];
      end else begin
         r = wd;
      end
      return r;
   endfunction

   logic port_ok;
   assign port_ok = (int'(port) < NUM_PORTS);

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      logic hit;
      assign hit = we && port_ok && (port == PIX_W'(p));

      logic [PORT_W-1:0] data_q, ostyle_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            data_q   <= '1;
            ostyle_q <= '0;
         end else begin
            if (hit && kind == RK_DATA)   data_q   <= merge(data_q, wdata, bit_en, bit_sel);
            if (hit && kind == RK_OSTYLE) ostyle_q <= merge(ostyle_q, wdata, bit_en, bit_sel);
         end
      end
      assign data_o[p*PORT_W +: PORT_W]   = data_q;
      assign ostyle_o[p*PORT_W +: PORT_W] = ostyle_q;

      if (p == ANALOG_PORT) begin : g_analog
         logic [PORT_W-1:0] istyle_q;
         always_ff @(posedge clk) begin
            if (!rst_n)                         istyle_q <= '1;
            else if (hit && kind == RK_ISTYLE)  istyle_q <= merge(istyle_q, wdata, bit_en, bit_sel);
         end
         assign istyle_o[p*PORT_W +: PORT_W] = istyle_q;
      end else begin : g_digital
         assign istyle_o[p*PORT_W +: PORT_W] = '1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pu_kill_o <= 1'b0;
      end else if (we && kind == RK_GLOBAL) begin
         if (!bit_en)          pu_kill_o <= wdata[0];
         else if (bit_sel == '0) pu_kill_o <= wdata[0];
      end
   end
endmodule

// File: rtl/pp_pin_cell.sv
module pp_pin_cell (
   input  logic data_bit,
   input  logic push_pull,
   input  logic analog,
   input  logic own,
   input  logic own_drive,
   input  logic own_level,
   input  logic pu_kill,
   input  logic pin_in,
   output logic oe,
   output logic out,
   output logic pu,
   output logic din
);
   logic level, released;

   always_comb begin
      level    = own ? own_level : data_bit;
      released = own && !own_drive;
      if (analog || released) begin
         oe  = 1'b0;
         out = 1'b0;
      end else if (push_pull) begin
         oe  = 1'b1;
         out = level;
      end else begin
         oe  = !level;
         out = 1'b0;
      end
      pu  = !analog && !pu_kill && !(oe && !out);
      din = analog ? 1'b0 : pin_in;
   end
endmodule

// File: rtl/pp_read_unit.sv
module pp_read_unit
   import pp_pkg::*;
#(
   parameter int NUM_PORTS = 4,
   parameter int PORT_W    = 8
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          re,
   input  logic                          rmw,
   input  logic [KIND_W-1:0]             kind,
   input  logic [$clog2(NUM_PORTS)-1:0]  port,
   input  logic [NUM_PORTS*PORT_W-1:0]   data_v,
   input  logic [NUM_PORTS*PORT_W-1:0]   ostyle_v,
   input  logic [NUM_PORTS*PORT_W-1:0]   istyle_v,
   input  logic [NUM_PORTS*PORT_W-1:0]   din_v,
   input  logic                          pu_kill,
   output logic [PORT_W-1:0]             rdata
);
   logic [PORT_W-1:0] sel_v;

   always_comb begin
      sel_v = '0;
      if (kind == RK_GLOBAL) begin
         sel_v[0] = pu_kill;
      end else if (int'(port) < NUM_PORTS) begin
         unique case (kind)
            RK_DATA:   sel_v = rmw ? data_v[port*PORT_W +: PORT_W] : din_v[port*PORT_W +: PORT_W];
            RK_OSTYLE: sel_v = ostyle_v[port*PORT_W +: PORT_W];
            RK_ISTYLE: sel_v = istyle_v[port*PORT_W +: PORT_W];
            default:   sel_v = '0;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)  rdata <= '0;
      else if (re) rdata <= sel_v;
   end
endmodule

// File: rtl/port_pin_ctrl.sv
module port_pin_ctrl
   import pp_pkg::*;
#(
   parameter int NUM_PORTS   = 4,
   parameter int PORT_W      = 8,
   parameter int ANALOG_PORT = 1
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic                                  bus_we,
   input  logic                                  bus_re,
   input  logic                                  bus_rmw,
   input  logic                                  bus_bit_en,
   input  logic [$clog2(PORT_W)-1:0]             bus_bit_sel,
   input  logic [KIND_W+$clog2(NUM_PORTS)-1:0]   bus_addr,
   input  logic [PORT_W-1:0]                     bus_wdata,
   output logic [PORT_W-1:0]                     bus_rdata,
   input  logic [NUM_PORTS*PORT_W-1:0]           pad_in,
   input  logic [NUM_PORTS*PORT_W-1:0]           xbar_own,
   input  logic [NUM_PORTS*PORT_W-1:0]           xbar_oe,
   input  logic [NUM_PORTS*PORT_W-1:0]           xbar_out,
   output logic [NUM_PORTS*PORT_W-1:0]           pad_oe,
   output logic [NUM_PORTS*PORT_W-1:0]           pad_out,
   output logic [NUM_PORTS*PORT_W-1:0]           pad_pu
);
   localparam int PIX_W = $clog2(NUM_PORTS);
   localparam int PIN_N = NUM_PORTS * PORT_W;

   if (NUM_PORTS < 2) begin : g_bad_ports
      $error("port_pin_ctrl: NUM_PORTS must be at least 2");
   end
   if (PORT_W < 2) begin : g_bad_width
      $error("port_pin_ctrl: PORT_W must be at least 2");
   end

   logic [KIND_W-1:0] kind;
   logic [PIX_W-1:0]  port;
   assign kind = bus_addr[KIND_W+PIX_W-1 -: KIND_W];
   assign port = bus_addr[PIX_W-1:0];

   logic [PIN_N-1:0] data_q, ostyle_q, istyle_q, analog_mask, din;
   logic             pu_kill_q;

   pp_regfile #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W), .ANALOG_PORT(ANALOG_PORT)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(bus_we), .bit_en(bus_bit_en), .bit_sel(bus_bit_sel),
      .kind(kind), .port(port), .wdata(bus_wdata),
      .data_o(data_q), .ostyle_o(ostyle_q), .istyle_o(istyle_q), .pu_kill_o(pu_kill_q)
   );

   assign analog_mask = ~istyle_q;

   for (genvar i = 0; i < PIN_N; i++) begin : g_pin
      pp_pin_cell u_cell (
         .data_bit(data_q[i]), .push_pull(ostyle_q[i]), .analog(analog_mask[i]),
         .own(xbar_own[i]), .own_drive(xbar_oe[i]), .own_level(xbar_out[i]),
         .pu_kill(pu_kill_q), .pin_in(pad_in[i]),
         .oe(pad_oe[i]), .out(pad_out[i]), .pu(pad_pu[i]), .din(din[i])
      );
   end

   pp_read_unit #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W)) u_read (
      .clk(clk), .rst_n(rst_n), .re(bus_re), .rmw(bus_rmw), .kind(kind), .port(port),
      .data_v(data_q), .ostyle_v(ostyle_q), .istyle_v(istyle_q), .din_v(din),
      .pu_kill(pu_kill_q), .rdata(bus_rdata)
   );
endmodule

// File: rtl/pp_checker.sv
module pp_checker
   import pp_pkg::*;
#(
   parameter int NUM_PORTS = 4,
   parameter int PORT_W    = 8
) (
   input logic                                clk,
   input logic                                rst_n,
   input logic                                bus_we,
   input logic                                bus_re,
   input logic                                bus_rmw,
   input logic                                bus_bit_en,
   input logic [KIND_W+$clog2(NUM_PORTS)-1:0] bus_addr,
   input logic [PORT_W-1:0]                   bus_wdata,
   input logic [PORT_W-1:0]                   bus_rdata,
   input logic [NUM_PORTS*PORT_W-1:0]         pad_oe,
   input logic [NUM_PORTS*PORT_W-1:0]         pad_out,
   input logic [NUM_PORTS*PORT_W-1:0]         pad_pu,
   input logic [NUM_PORTS*PORT_W-1:0]         data_q,
   input logic [NUM_PORTS*PORT_W-1:0]         analog_mask,
   input logic                                pu_kill_q
);
   localparam int PIX_W = $clog2(NUM_PORTS);

   logic [KIND_W-1:0] c_kind;
   logic [PIX_W-1:0]  c_port;
   logic              c_port_ok;
   assign c_kind    = bus_addr[KIND_W+PIX_W-1 -: KIND_W];
   assign c_port    = bus_addr[PIX_W-1:0];
   assign c_port_ok = (int'(c_port) < NUM_PORTS);

   // R4: no pin may keep its pull-up while driving low
   p_pu_off_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_oe & ~pad_out & pad_pu) == '0);

   // R5: global kill removes every pull-up
   p_pu_kill_r5: assert property (@(posedge clk) disable iff (!rst_n)
      pu_kill_q |-> (pad_pu == '0));

   // R9: analog pins neither drive nor pull up
   p_analog_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ((analog_mask & (pad_oe | pad_pu)) == '0));

   // R8: whole-byte data write lands in the latch
   p_byte_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && !bus_bit_en && c_kind == RK_DATA && c_port_ok)
      |=> data_q[$past(c_port)*PORT_W +: PORT_W] == $past(bus_wdata));

   // R7: read-modify-write read returns latch contents
   p_rmw_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_re && bus_rmw && c_kind == RK_DATA && c_port_ok && !bus_we)
      |=> bus_rdata == $past(data_q[c_port*PORT_W +: PORT_W]));

   // R12: read data holds without a read strobe
   p_rdata_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_re |=> $stable(bus_rdata));
endmodule

bind port_pin_ctrl pp_checker #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re), .bus_rmw(bus_rmw),
   .bus_bit_en(bus_bit_en), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
   .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu),
   .data_q(data_q), .analog_mask(analog_mask), .pu_kill_q(pu_kill_q)
);

// File: tb/test_port_pin_ctrl.sv
module test_port_pin_ctrl;
   localparam int NP = 4;
   localparam int PW = 8;
   localparam int N  = NP * PW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_we = 1'b0, bus_re = 1'b0, bus_rmw = 1'b0, bus_bit_en = 1'b0;
   logic [2:0]    bus_bit_sel = '0;
   logic [3:0]    bus_addr = '0;
   logic [7:0]    bus_wdata = '0;
   logic [7:0]    bus_rdata;
   logic [N-1:0]  pad_in = '0, xbar_own = '0, xbar_oe = '0, xbar_out = '0;
   logic [N-1:0]  pad_oe, pad_out, pad_pu;

   int total = 0;
   int bad   = 0;
   logic rd_due = 1'b0;
   logic [7:0] exp_q[$];
   string      tag_q[$];

   always #5 clk = ~clk;

   port_pin_ctrl i_port_pin_ctrl (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re), .bus_rmw(bus_rmw),
      .bus_bit_en(bus_bit_en), .bus_bit_sel(bus_bit_sel), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
      .xbar_own(xbar_own), .xbar_oe(xbar_oe), .xbar_out(xbar_out),
      .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] kind, input logic [1:0] port, input logic [7:0] val);
      @(negedge clk);
      bus_we = 1'b1; bus_bit_en = 1'b0; bus_addr = {kind, port}; bus_wdata = val;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic wrbit(input logic [1:0] kind, input logic [1:0] port,
                        input logic [2:0] b, input logic v);
      @(negedge clk);
      bus_we = 1'b1; bus_bit_en = 1'b1; bus_bit_sel = b; bus_addr = {kind, port};
      bus_wdata = {7'b1010101, v};
      @(negedge clk);
      bus_we = 1'b0; bus_bit_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] kind, input logic [1:0] port, input logic rmw,
                     input logic [7:0] exp, input string tag);
      @(negedge clk);
      bus_re = 1'b1; bus_rmw = rmw; bus_addr = {kind, port};
      exp_q.push_back(exp);
      tag_q.push_back(tag);
      @(negedge clk);
      bus_re = 1'b0; bus_rmw = 1'b0;
   endtask

   always @(posedge clk) rd_due <= bus_re && rst_n;

   always @(negedge clk) begin
      if (rd_due) begin
         if (exp_q.size() == 0) begin
            total++; bad++;
            $display("FAIL R12: read data with no queued expectation actual=%h expected=none", bus_rdata);
         end else begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, 32'(bus_rdata), 32'(e));
         end
      end
   end

   initial begin
      #(200000 * 10);
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check("R1 pad_oe", pad_oe, '0);
      check("R1 pad_pu", pad_pu, '1);
      rd(2'd0, 2'd3, 1'b1, 8'hFF, "R1 data latch reset");

      // R2 push-pull, R4 pull-up off on low pins
      wr(2'd1, 2'd0, 8'hFF);
      wr(2'd0, 2'd0, 8'hA5);
      check("R2 oe port0",  32'(pad_oe[7:0]),  32'hFF);
      check("R2 out port0", 32'(pad_out[7:0]), 32'hA5);
      check("R4 pu port0",  32'(pad_pu[7:0]),  32'hA5);

      // R3 open-drain
      wr(2'd0, 2'd2, 8'h3C);
      check("R3 oe port2",  32'(pad_oe[23:16]),  32'hC3);
      check("R3 out port2", 32'(pad_out[23:16]), 32'h00);
      check("R4 pu port2",  32'(pad_pu[23:16]),  32'h3C);

      // R8 single-bit writes
      wrbit(2'd0, 2'd2, 3'd0, 1'b1);
      wrbit(2'd0, 2'd2, 3'd5, 1'b0);
      rd(2'd0, 2'd2, 1'b1, 8'h1D, "R8 bit writes");
      check("R3 oe after bit writes", 32'(pad_oe[23:16]), 32'hE2);

      // R6 normal read sees pads, R7 rmw read sees latch
      pad_in[23:16] = 8'h5A;
      rd(2'd0, 2'd2, 1'b0, 8'h5A, "R6 pin read");
      rd(2'd0, 2'd2, 1'b1, 8'h1D, "R7 latch read");

      // R5 global pull-up kill
      wr(2'd3, 2'd0, 8'h01);
      check("R5 pu killed", pad_pu, '0);
      rd(2'd3, 2'd0, 1'b0, 8'h01, "R5 readback");
      wr(2'd3, 2'd0, 8'h00);
      check("R5 pu restored", 32'(pad_pu[23:16]), 32'h1D);

      // R9 analog pins on port 1
      wr(2'd2, 2'd1, 8'hF0);
      wr(2'd1, 2'd1, 8'hFF);
      check("R9 oe port1",  32'(pad_oe[15:8]),  32'hF0);
      check("R9 out port1", 32'(pad_out[15:8]), 32'hF0);
      check("R9 pu port1",  32'(pad_pu[15:8]),  32'hF0);
      pad_in[15:8] = 8'hFF;
      rd(2'd0, 2'd1, 1'b0, 8'hF0, "R9 analog reads zero");
      rd(2'd2, 2'd1, 1'b0, 8'hF0, "R9 style readback");

      // R11 input style ignored on port 3
      wr(2'd2, 2'd3, 8'h00);
      rd(2'd2, 2'd3, 1'b0, 8'hFF, "R11 style stays FF");
      check("R11 oe port3", 32'(pad_oe[31:24]), 32'h00);
      check("R11 pu port3", 32'(pad_pu[31:24]), 32'hFF);
      pad_in[31:24] = 8'hC3;
      rd(2'd0, 2'd3, 1'b0, 8'hC3, "R11 port3 stays digital");

      // R10 peripheral-owned pins
      wr(2'd0, 2'd0, 8'hA0);
      xbar_own[7:0] = 8'h0F;
      xbar_oe[7:0]  = 8'h07;
      xbar_out[7:0] = 8'h05;
      @(negedge clk);
      check("R10 pp oe",  32'(pad_oe[7:0]),  32'hF7);
      check("R10 pp out", 32'(pad_out[7:0]), 32'hA5);
      check("R10 pp pu",  32'(pad_pu[7:0]),  32'hAD);
      pad_in[7:0] = 8'h33;
      rd(2'd0, 2'd0, 1'b0, 8'h33, "R6 owned pin read");
      wr(2'd1, 2'd0, 8'h00);
      check("R10 od oe",  32'(pad_oe[7:0]),  32'h52);
      check("R10 od out", 32'(pad_out[7:0]), 32'h00);
      check("R10 od pu",  32'(pad_pu[7:0]),  32'hAD);
      rd(2'd0, 2'd0, 1'b1, 8'hA0, "R7 owned latch read");

      // R12 hold
      pad_in = '1;
      repeat (3) @(negedge clk);
      check("R12 rdata holds", 32'(bus_rdata), 32'hA0);

      repeat (2) @(negedge clk);
      if (exp_q.size() != 0) begin
         total++; bad++;
         $display("FAIL R12: pending reads actual=%0d expected=0", exp_q.size());
      end
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule